// File: doc/BRIEF.md
# Serial Programming Command Slave

This block is the target end of a three-wire programming port. An external serial clock drives it; on each rising edge it samples one bit from a data lane and one bit from an instruction lane. The bits are grouped into fixed 11-bit frames. The payload bytes of the two lanes are decoded together, one frame at a time. A short series of frames forms a command. The commands erase the whole store, write or read one 16-bit word of a 512-word program array, or write and read a small fuse register. Read results go back on a separate output lane.

A host clocks frames without gaps, back to back, from the release of reset. Frame alignment is purely positional: the slave counts edges from reset and treats every eleventh edge as the end of a frame. Chip erase is the only long operation. While it runs, a busy output is high, the array is cleared one word per clock in the background, and every frame that completes is discarded. The edge count still advances during this time, so framing stays aligned.

Top module: `serprog_slave`

## Requirements
- R1: A frame is 11 bits sampled on 11 consecutive rising edges, starting with the first edge after reset and with no gaps between frames. Bit 0 is a leading pad, bits 1 to 8 carry the payload most significant bit first, and bits 9 and 10 are trailing pads. The values of the pad bits have no effect.
- R2: A command frame with data payload 0x80 and instruction payload 0x4C erases the store. After the erase every word of the array reads 0xFFFF and the fuse register reads 0.
- R3: The busy output rises on the edge that ends the erase frame. It then stays high for exactly ERASE_CYCLES sampled edges (default 600) and falls.
- R4: Every frame that completes while busy is high is discarded, and so is the command it would have started or continued.
- R5: A word write is five frames: a command frame with data payload 0x10 and instruction payload 0x4C, then address bits 7..0, then a frame whose payload bit 0 is address bit 8, then the low byte, then the high byte. The word is stored when the last frame ends.
- R6: A word read is a command frame with data payload 0x02 (low byte) or 0x03 (high byte) and instruction payload 0x4C, followed by the two address frames. In the frame after the address, the output lane carries the selected byte MSB first: after edge k of that frame (k = 1..8) the output shows byte bit 8-k.
- R7: A command frame with data payload 0x40 and instruction payload 0x4C, followed by one data frame, loads that frame's payload bits 3..0 into the 4-bit fuse register. A command frame with data payload 0x04 and instruction payload 0x4C returns the fuse register, zero-extended to 8 bits, in the next frame in the same way as R6.
- R8: A command frame whose instruction payload is not 0x4C, or whose data payload is not a defined code, is ignored. The next frame is again taken as a command frame.
- R9: During reset and right after it, busy and the output lane are 0. The output lane stays 0 in every frame that does not carry read data.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Serial clock; all lanes are sampled on its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset; restarts frame alignment |
| sdi | input | 1 | Data lane (addresses, data bytes, command codes) |
| sii | input | 1 | Instruction lane (command key) |
| sdo | output | 1 | Output lane carrying read bytes |
| busy | output | 1 | High while a chip erase is in progress |

## Verification
Each result has a fixed due cycle, counted from the edge that ends the frame causing it:
- A stored word or fuse value is visible to the next read command.
- Busy is already high when sampled just after the last edge of the erase frame.
- A read byte appears on the output lane after edges 1 to 8 of the following frame.

The bench drives every bit half a period before its edge and samples 1 ns after the edge. It captures the output-lane byte inside the frame task at exactly those edge positions. It counts high busy samples across the erase frame and the idle frames after it, and compares that count with ERASE_CYCLES. Effects that should be ignored are observed by reading back through the normal read commands once busy has fallen. These include writes attempted during busy, malformed commands and set pad bits.

// File: rtl/serprog_pkg.sv
package serprog_pkg;
   // frame geometry: one leading pad, payload, two trailing pads
   localparam int PAY_W     = 8;
   localparam int FRAME_LEN = PAY_W + 3;

   // data-lane command codes (valid only with the instruction key)
   localparam logic [PAY_W-1:0] OP_ERASE   = 8'h80;
   localparam logic [PAY_W-1:0] OP_FUSE_WR = 8'h40;
   localparam logic [PAY_W-1:0] OP_WORD_WR = 8'h10;
   localparam logic [PAY_W-1:0] OP_FUSE_RD = 8'h04;
   localparam logic [PAY_W-1:0] OP_RD_LO   = 8'h02;
   localparam logic [PAY_W-1:0] OP_RD_HI   = 8'h03;

   typedef enum logic [2:0] {
      ST_CMD, ST_ALO, ST_AHI, ST_DLO, ST_DHI, ST_FUSE, ST_OUT
   } seq_state_t;

   typedef enum logic [1:0] {
      ACC_WRITE, ACC_RD_LO, ACC_RD_HI
   } access_t;
endpackage

// File: rtl/serprog_frame_rx.sv
module serprog_frame_rx
   import serprog_pkg::*;
#(
   parameter  int LANES = 2,
   localparam int CNT_W = $clog2(FRAME_LEN)
) (
   input  logic                        clk,
   input  logic                        rst_n,
   input  logic [LANES-1:0]            lane_in,
   output logic                        frame_done,
   output logic [LANES-1:0][PAY_W-1:0] payload,
   output logic [CNT_W-1:0]            bit_pos
);
   localparam logic [CNT_W-1:0] LAST = CNT_W'(FRAME_LEN - 1);

   // the edge that samples the last pad bit completes the frame
   assign frame_done = (bit_pos == LAST);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)          bit_pos <= '0;
      else if (frame_done) bit_pos <= '0;
      else                 bit_pos <= bit_pos + 1'b1;
   end

   for (genvar g = 0; g < LANES; g++) begin : g_lane
      logic [FRAME_LEN-2:0] sr;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) sr <= '0;
         else        sr <= {sr[FRAME_LEN-3:0], lane_in[g]};
      end
      // before the last edge: sr[FRAME_LEN-2] is the leading pad, sr[0] the first trailing pad
      assign payload[g] = sr[FRAME_LEN-3:1];
   end
endmodule

// File: rtl/serprog_tx.sv
module serprog_tx
   import serprog_pkg::*;
(
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load,
   input  logic [PAY_W-1:0] byte_in,
   output logic             sdo
);
   logic [FRAME_LEN-1:0] osr;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    osr <= '0;
      else if (load) osr <= {1'b0, byte_in, 2'b00};
      else           osr <= {osr[FRAME_LEN-2:0], 1'b0};
   end

   assign sdo = osr[FRAME_LEN-1];
endmodule

// File: rtl/serprog_store.sv
module serprog_store
   import serprog_pkg::*;
#(
   parameter  int ADDR_W       = 9,
   parameter  int ERASE_CYCLES = 600,
   localparam int DEPTH        = 1 << ADDR_W,
   localparam int WORD_W       = 2 * PAY_W,
   localparam int TMR_W        = $clog2(ERASE_CYCLES + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              erase_go,
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] wr_addr,
   input  logic [WORD_W-1:0] wr_data,
   input  logic [ADDR_W-1:0] rd_addr,
   output logic [WORD_W-1:0] rd_data,
   output logic              busy
);
   logic [WORD_W-1:0] mem [DEPTH];
   logic [TMR_W-1:0]  tmr;
   logic [TMR_W-1:0]  sweep;
   logic              sweep_hit;

   assign busy      = (tmr != '0);
   assign sweep     = TMR_W'(ERASE_CYCLES) - tmr;
   assign sweep_hit = busy && (int'(sweep) < DEPTH);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        tmr <= '0;
      else if (erase_go) tmr <= TMR_W'(ERASE_CYCLES);
      else if (busy)     tmr <= tmr - 1'b1;
   end

   // one word cleared per clock while busy; external writes cannot arrive then
   always_ff @(posedge clk) begin
      if (sweep_hit)  mem[sweep[ADDR_W-1:0]] <= '1;
      else if (wr_en) mem[wr_addr] <= wr_data;
   end

   assign rd_data = mem[rd_addr];
endmodule

// File: rtl/serprog_slave.sv
module serprog_slave
   import serprog_pkg::*;
#(
   parameter int               ADDR_W       = 9,
   parameter int               FUSE_W       = 4,
   parameter int               ERASE_CYCLES = 600,
   parameter logic [PAY_W-1:0] INSTR_KEY    = 8'h4C
) (
   input  logic clk,
   input  logic rst_n,
   input  logic sdi,
   input  logic sii,
   output logic sdo,
   output logic busy
);
   localparam int DEPTH  = 1 << ADDR_W;
   localparam int WORD_W = 2 * PAY_W;
   localparam int CNT_W  = $clog2(FRAME_LEN);

   if (ADDR_W < 1 || ADDR_W > WORD_W) begin : g_bad_addr
      $error("ADDR_W must lie in 1..%0d", WORD_W);
   end
   if (FUSE_W < 1 || FUSE_W > PAY_W) begin : g_bad_fuse
      $error("FUSE_W must lie in 1..%0d", PAY_W);
   end
   if (ERASE_CYCLES < DEPTH) begin : g_bad_erase
      $error("ERASE_CYCLES must cover all %0d words", DEPTH);
   end

   logic                    rx_done;
   logic [1:0][PAY_W-1:0]   pay;
   logic [CNT_W-1:0]        bit_pos;
   logic [PAY_W-1:0]        dpay, ipay;
   logic                    accept, key_ok;
   seq_state_t              state_q;
   access_t                 acc_q;
   logic [PAY_W-1:0]        addr_lo_q, dlo_q;
   logic [ADDR_W-1:0]       addr_q, addr_new;
   logic [FUSE_W-1:0]       fuse_q;
   logic [PAY_W-1:0]        fuse_byte, tx_byte;
   logic [WORD_W-1:0]       rd_data;
   logic                    tx_load, erase_go, wr_en;

   serprog_frame_rx #(.LANES(2)) rx_i (
      .clk        (clk),
      .rst_n      (rst_n),
      .lane_in    ({sii, sdi}),
      .frame_done (rx_done),
      .payload    (pay),
      .bit_pos    (bit_pos)
   );

   assign dpay   = pay[0];
   assign ipay   = pay[1];
   assign accept = rx_done && !busy;
   assign key_ok = (ipay == INSTR_KEY);

   // address assembly: high frame is used only when the array needs it
   if (ADDR_W > PAY_W) begin : g_addr_two
      logic [WORD_W-1:0] addr_cat;
      assign addr_cat = {dpay, addr_lo_q};
      assign addr_new = addr_cat[ADDR_W-1:0];
   end else begin : g_addr_one
      assign addr_new = addr_lo_q[ADDR_W-1:0];
   end

   if (FUSE_W == PAY_W) begin : g_fuse_full
      assign fuse_byte = fuse_q;
   end else begin : g_fuse_pad
      assign fuse_byte = {{(PAY_W-FUSE_W){1'b0}}, fuse_q};
   end

   assign erase_go = accept && (state_q == ST_CMD) && key_ok && (dpay == OP_ERASE);
   assign wr_en    = accept && (state_q == ST_DHI);
   assign tx_load  = accept && (((state_q == ST_CMD) && key_ok && (dpay == OP_FUSE_RD)) ||
                                ((state_q == ST_AHI) && (acc_q != ACC_WRITE)));
   assign tx_byte  = (state_q != ST_AHI)   ? fuse_byte :
                     (acc_q == ACC_RD_HI)  ? rd_data[WORD_W-1:PAY_W] :
                                             rd_data[PAY_W-1:0];

   serprog_store #(.ADDR_W(ADDR_W), .ERASE_CYCLES(ERASE_CYCLES)) store_i (
      .clk      (clk),
      .rst_n    (rst_n),
      .erase_go (erase_go),
      .wr_en    (wr_en),
      .wr_addr  (addr_q),
      .wr_data  ({dpay, dlo_q}),
      .rd_addr  (addr_new),
      .rd_data  (rd_data),
      .busy     (busy)
   );

   serprog_tx tx_i (
      .clk     (clk),
      .rst_n   (rst_n),
      .load    (tx_load),
      .byte_in (tx_byte),
      .sdo     (sdo)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q   <= ST_CMD;
         acc_q     <= ACC_WRITE;
         addr_lo_q <= '0;
         addr_q    <= '0;
         dlo_q     <= '0;
         fuse_q    <= '0;
      end else begin
         if (erase_go) fuse_q <= '0;
         if (accept) begin
            unique case (state_q)
               ST_CMD: if (key_ok) begin
                  unique case (dpay)
                     OP_FUSE_WR: state_q <= ST_FUSE;
                     OP_FUSE_RD: state_q <= ST_OUT;
                     OP_WORD_WR: begin acc_q <= ACC_WRITE; state_q <= ST_ALO; end
                     OP_RD_LO:   begin acc_q <= ACC_RD_LO; state_q <= ST_ALO; end
                     OP_RD_HI:   begin acc_q <= ACC_RD_HI; state_q <= ST_ALO; end
                     default:    state_q <= ST_CMD;
                  endcase
               end
               ST_ALO: begin
                  addr_lo_q <= dpay;
                  state_q   <= ST_AHI;
               end
               ST_AHI: begin
                  addr_q  <= addr_new;
                  state_q <= (acc_q == ACC_WRITE) ? ST_DLO : ST_OUT;
               end
               ST_DLO: begin
                  dlo_q   <= dpay;
                  state_q <= ST_DHI;
               end
               ST_FUSE: begin
                  fuse_q  <= dpay[FUSE_W-1:0];
                  state_q <= ST_CMD;
               end
               default: state_q <= ST_CMD;
            endcase
         end
      end
   end
endmodule

// File: rtl/serprog_slave_chk.sv
module serprog_slave_chk
   import serprog_pkg::*;
#(
   parameter int ERASE_CYCLES = 600,
   parameter int FUSE_W       = 4
) (
   input logic                         clk,
   input logic                         rst_n,
   input logic                         busy,
   input logic                         sdo,
   input logic                         frame_done,
   input logic [$clog2(FRAME_LEN)-1:0] bit_pos,
   input seq_state_t                   state,
   input logic [FUSE_W-1:0]            fuse
);
   logic [31:0] run;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    run <= '0;
      else if (busy) run <= run + 1;
      else           run <= '0;
   end

   AST_FRAME_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
      frame_done |=> (bit_pos == '0)); // R1
   AST_BUSY_FROM_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(busy) |-> $past(frame_done)); // R3
   AST_BUSY_RUN_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
      busy |-> (run < ERASE_CYCLES)); // R3
   AST_FUSE_CLEARED: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(busy) |-> (fuse == '0)); // R2
   AST_HOLD_WHILE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
      $past(busy) |-> $stable(state)); // R4
   AST_SDO_QUIET_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
      busy |-> !sdo); // R9
endmodule

bind serprog_slave serprog_slave_chk #(
   .ERASE_CYCLES (ERASE_CYCLES),
   .FUSE_W       (FUSE_W)
) chk_i (
   .clk        (clk),
   .rst_n      (rst_n),
   .busy       (busy),
   .sdo        (sdo),
   .frame_done (rx_done),
   .bit_pos    (bit_pos),
   .state      (state_q),
   .fuse       (fuse_q)
);

// File: tb/serprog_slave_tb_top.sv
module serprog_slave_tb_top;
   localparam int N_ERASE = 600;
   localparam int WORDS   = 512;
   localparam logic [7:0] KEY = 8'h4C;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic sdi = 1'b0;
   logic sii = 1'b0;
   logic sdo, busy;

   int tests = 0;
   int fails = 0;
   int busy_hi = 0;
   int sdo_hi = 0;
   bit done = 1'b0;

   always #4 clk = ~clk;

   serprog_slave #(.ERASE_CYCLES(N_ERASE)) dut_i (
      .clk(clk), .rst_n(rst_n), .sdi(sdi), .sii(sii), .sdo(sdo), .busy(busy)
   );

   function automatic logic [15:0] pat(int a);
      return 16'((a * 40503) ^ 50085);
   endfunction

   task automatic check(string req, logic [31:0] act, logic [31:0] exp);
      tests++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   // one frame: bit j driven before edge j+1, sampled 1 ns after it
   task automatic frame_raw(input logic [10:0] df, input logic [10:0] ifr, output logic [7:0] rd);
      rd = '0;
      for (int j = 0; j < 11; j++) begin
         @(negedge clk);
         sdi = df[10-j];
         sii = ifr[10-j];
         @(posedge clk);
         #1;
         if (busy) busy_hi++;
         if (sdo) sdo_hi++;
         if (j < 8) rd[7-j] = sdo;
      end
   endtask

   task automatic frame(input logic [7:0] d, input logic [7:0] i, output logic [7:0] rd);
      frame_raw({1'b0, d, 2'b00}, {1'b0, i, 2'b00}, rd);
   endtask

   task automatic write_word(input int a, input logic [15:0] w);
      logic [7:0] x;
      frame(8'h10, KEY, x);
      frame(8'(a), 8'h00, x);
      frame(8'(a >> 8), 8'h00, x);
      frame(w[7:0], 8'h00, x);
      frame(w[15:8], 8'h00, x);
   endtask

   task automatic read_byte(input int a, input bit hi, output logic [7:0] b);
      logic [7:0] x;
      frame(hi ? 8'h03 : 8'h02, KEY, x);
      frame(8'(a), 8'h00, x);
      frame(8'(a >> 8), 8'h00, x);
      frame(8'h00, 8'h00, b);
   endtask

   task automatic read_fuse(output logic [7:0] b);
      logic [7:0] x;
      frame(8'h04, KEY, x);
      frame(8'h00, 8'h00, b);
   endtask

   task automatic idle_until_free();
      logic [7:0] x;
      for (int k = 0; k < 100 && busy; k++) frame(8'h00, 8'h00, x);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         fails++;
         $display("FAIL watchdog actual=timeout expected=finish");
         $display("[TB] %0d tests run, %0d failed", tests, fails);
         $finish;
      end
   end

   initial begin
      logic [7:0] b, x;
      repeat (3) @(posedge clk);
      #1;
      check("R9 reset busy", 32'(busy), 0);
      check("R9 reset sdo", 32'(sdo), 0);
      @(posedge clk);
      #1;
      rst_n = 1'b1;

      // R2/R3: first erase, busy length
      busy_hi = 0;
      frame(8'h80, KEY, x);
      check("R3 busy right after erase frame", 32'(busy), 1);
      idle_until_free();
      check("R3 busy length", 32'(busy_hi), N_ERASE);
      for (int a = 0; a < WORDS; a++) begin
         read_byte(a, 1'b1, b);
         check("R2 erased high byte", 32'(b), 32'hFF);
      end
      read_byte(0, 1'b0, b);
      check("R2 erased low byte 0", 32'(b), 32'hFF);
      read_byte(WORDS-1, 1'b0, b);
      check("R2 erased low byte 511", 32'(b), 32'hFF);
      read_fuse(b);
      check("R2 fuse after erase", 32'(b), 0);

      // R7 + R1: fuse write with every pad bit set and a junk instruction frame
      frame(8'h40, KEY, x);
      frame_raw({1'b1, 8'hFA, 2'b11}, 11'h7FF, x);
      read_fuse(b);
      check("R7 R1 fuse readback, pads ignored", 32'(b), 32'h0A);

      // R9: no output activity during non-read frames
      sdo_hi = 0;
      write_word(3, 16'hFFFF);
      frame(8'h00, 8'h00, x);
      check("R9 sdo quiet outside reads", 32'(sdo_hi), 0);

      // R5/R6: write then read back every address
      for (int a = 0; a < WORDS; a++) write_word(a, pat(a));
      for (int a = 0; a < WORDS; a++) begin
         read_byte(a, 1'b0, b);
         check("R6 R5 low byte", 32'(b), 32'(pat(a) & 16'h00FF));
         read_byte(a, 1'b1, b);
         check("R6 R5 high byte", 32'(b), 32'(pat(a) >> 8));
      end

      // R8: bad key with erase code, unknown code, then a normal read
      frame(8'h80, 8'h4D, x);
      check("R8 bad key erase not started", 32'(busy), 0);
      frame(8'h55, KEY, x);
      read_byte(300, 1'b1, b);
      check("R8 command state kept", 32'(b), 32'(pat(300) >> 8));
      read_fuse(b);
      check("R8 fuse untouched", 32'(b), 32'h0A);

      // R4: write attempt during a second erase is discarded
      busy_hi = 0;
      frame(8'h80, KEY, x);
      write_word(5, 16'h1234);
      frame(8'h40, KEY, x);
      frame(8'h07, 8'h00, x);
      idle_until_free();
      check("R3 busy length second erase", 32'(busy_hi), N_ERASE);
      read_byte(5, 1'b0, b);
      check("R4 ignored write low", 32'(b), 32'hFF);
      read_byte(5, 1'b1, b);
      check("R4 ignored write high", 32'(b), 32'hFF);
      read_fuse(b);
      check("R4 R2 fuse cleared, write ignored", 32'(b), 0);
      read_byte(WORDS-1, 1'b0, b);
      check("R2 last word erased", 32'(b), 32'hFF);

      done = 1'b1;
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end
endmodule